// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds a small bank of independent 32-bit interval timers behind a plain single-cycle register bus. Each channel has a down-counter, a reload value and a 16-bit control word. A shared start register runs or halts each channel. While a channel runs, its own prescaler divides the system clock by a power of four. Each divided tick lowers the counter by one.

A tick that finds the counter at zero is an underflow. On underflow the counter takes the reload value and a sticky status flag is raised. When that channel's enable bit is set, the flag also drives its interrupt line. Software sets a period by writing the reload and counter registers while the channel is halted, then starts it. A reload value of zero gives a single-shot run.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Byte lanes are selected by `bus_be`. All addresses are byte offsets of 32-bit words.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every reload and counter register reads 0xFFFFFFFF. Every control word, the start register and every interrupt output are 0.
- R2: The start register is at offset 0x04. For channel n, the reload register is at 0x08+12n, the counter at 0x0C+12n and the control word at 0x10+12n. Any other offset reads 0.
- R3: Bit n of the start register runs channel n when 1 and halts it when 0. A halted channel keeps its counter value. Halting also clears the channel's prescaler.
- R4: Control bits 2:0 select the divide ratio 4<<(2·code), so codes 0 to 3 give 4, 16, 64 and 256. The first decrement comes exactly that many clocks after the edge that sets the start bit, and each later decrement comes one ratio after the previous one.
- R5: A tick with the counter at 0 is an underflow. The counter loads the reload value and control bit 8 (the flag) becomes 1. With counter N and reload C, the first underflow comes at tick N+1 and each later one C+1 ticks after it.
- R6: When an underflow loads a reload value of 0, later ticks change nothing and raise no flag. This lasts until software writes the counter or the reload register.
- R7: Writing 0 to control bit 8 (through byte lane 1) clears the flag. Writing 1 leaves it unchanged. An underflow on the same edge as a clearing write leaves the flag set.
- R8: Interrupt output n is registered, and equals the AND of channel n's flag and its enable (control bit 5) from one clock earlier.
- R9: Control codes 4 to 7 are reserved. With one of them selected, a running channel's counter does not change.
- R10: Writes to 32-bit registers update only the bytes whose `bus_be` bit is set. The start register uses byte lane 0 and the control word uses lanes 0 and 1.
- R11: Channels are independent. Running or writing one channel leaves the others' counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the addressed word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Per-channel interrupt request |

## Verification
The main function is swept over all four prescaler codes, each with starting counts of 0, 1 and 2 and a fixed reload. The exact edge of the first underflow separates the prescaler ratio from the underflow-at-zero rule. The cycle just before it shows that nothing fires early. A second full period then checks that the reload value, not the original count, sets the interval. Further runs check the special cases one at a time: a zero reload, a reserved code, halting and restarting mid-period, a clear timed onto an underflow edge, and one channel running alone. Each tells apart parking, freezing, prescaler reset, flag priority and channel isolation.

// File: rtl/tmr_pkg.sv
// Shared constants and helpers for the timer bank.
// Assumes a 32-bit bus with four byte lanes and byte-offset addressing.
package tmr_pkg;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned LANES     = BUS_W / 8;
    localparam int unsigned START_OFF = 4;
    localparam int unsigned CH_BASE   = 8;
    localparam int unsigned CH_STRIDE = 12;
    localparam int unsigned RLD_REL   = 0;
    localparam int unsigned CNT_REL   = 4;
    localparam int unsigned CTL_REL   = 8;
    localparam int unsigned FLAG_BIT  = 8;
    localparam int unsigned IE_BIT    = 5;

    // Replace only the enabled byte lanes of a word.
    function automatic logic [BUS_W-1:0] merge_bytes(input logic [BUS_W-1:0] old_v,
                                                      input logic [BUS_W-1:0] new_v,
                                                      input logic [LANES-1:0]  be);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < int'(LANES); i++)
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running per-channel clock divider.
// Emits a one-cycle tick every 4<<(2*code) clocks while run is high.
// Codes at or above NUM_CODES never tick. The count is cleared while halted.
module tmr_prescaler #(
    parameter int unsigned NUM_CODES = 4,
    parameter int unsigned CODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int unsigned PRE_W = 2 + 2 * (NUM_CODES - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic             code_ok;

    // Terminal count for the selected ratio.
    always_comb begin
        limit   = '0;
        code_ok = 1'b0;
        for (int i = 0; i < int'(NUM_CODES); i++) begin
            if (code == CODE_W'(i)) begin
                limit   = PRE_W'((1 << (2 + 2 * i)) - 1);
                code_ok = 1'b1;
            end
        end
    end

    assign tick = run && code_ok && (pre_cnt == limit);

    // Divider count: cleared when halted or frozen, wraps on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !code_ok) pre_cnt <= '0;
        else if (tick)                  pre_cnt <= '0;
        else                            pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: reload value, down-counter, control word and interrupt.
// Assumes the write strobes come from the bus decoder, one cycle each.
// A counter write takes priority over a tick on the same edge.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LANES-1:0] rld_we,
    input  logic [LANES-1:0] cnt_we,
    input  logic             ctl_lo_we,
    input  logic             ctl_hi_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic [2:0]       psc_d,
    input  logic             ie_d,
    input  logic             flag_d,
    output logic [BUS_W-1:0] rld_q,
    output logic [BUS_W-1:0] cnt_q,
    output logic [15:0]      ctl_q,
    output logic             irq
);
    logic [2:0] psc;
    logic       ie;
    logic       flag;
    logic       spent;
    logic       tick;
    logic       cnt_wr;
    logic       uf;

    tmr_prescaler #(.NUM_CODES(NUM_CODES), .CODE_W(3)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .code (psc),
        .tick (tick)
    );

    assign cnt_wr = |cnt_we;
    assign uf     = tick && !spent && (cnt_q == '0) && !cnt_wr;
    assign ctl_q  = {7'b0, flag, 2'b0, ie, 2'b0, psc};

    // Reload register with byte-lane writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        rld_q <= '1;
        else if (|rld_we)  rld_q <= merge_bytes(rld_q, wdata, rld_we);
    end

    // Counter: software write, otherwise decrement or reload on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '1;
        else if (cnt_wr)           cnt_q <= merge_bytes(cnt_q, wdata, cnt_we);
        else if (uf)               cnt_q <= rld_q;
        else if (tick && !spent)   cnt_q <= cnt_q - 1'b1;
    end

    // Parked state after a zero reload, released by any counter or reload write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   spent <= 1'b0;
        else if (cnt_wr || |rld_we)   spent <= 1'b0;
        else if (uf)                  spent <= (rld_q == '0);
    end

    // Control fields from byte lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc <= '0;
            ie  <= 1'b0;
        end else if (ctl_lo_we) begin
            psc <= psc_d;
            ie  <= ie_d;
        end
    end

    // Sticky flag: underflow sets it, a written 0 clears it, underflow wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= uf | (flag & ~(ctl_hi_we & ~flag_d));
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= flag & ie;
    end

    // R3
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    // R9
    reserved_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psc >= 3'(NUM_CODES) && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    // R5
    underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !spent && cnt_q == '0 && !cnt_wr && !(|rld_we)) |=> (flag && cnt_q == $past(rld_q)));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctl_hi_we) |=> flag);

    // R6
    parked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spent && !cnt_wr && !(|rld_we)) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_bank.sv
// Timer bank top: register decode, shared start register, channel array and
// combinational read mux. Assumes single-cycle writes and word-aligned offsets.
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH    = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_CODES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(START_OFF);

    logic [NUM_CH-1:0] start_q;
    logic [BUS_W-1:0]  rld_v [NUM_CH];
    logic [BUS_W-1:0]  cnt_v [NUM_CH];
    logic [15:0]       ctl_v [NUM_CH];

    // Shared start register on byte lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        start_q <= '0;
        else if (bus_wr && bus_addr == A_START && bus_be[0]) start_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(CH_BASE + CH_STRIDE * n + RLD_REL);
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CH_BASE + CH_STRIDE * n + CNT_REL);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CH_BASE + CH_STRIDE * n + CTL_REL);

        logic hit_rld, hit_cnt, hit_ctl;
        assign hit_rld = bus_wr && (bus_addr == A_RLD);
        assign hit_cnt = bus_wr && (bus_addr == A_CNT);
        assign hit_ctl = bus_wr && (bus_addr == A_CTL);

        tmr_channel #(.NUM_CODES(NUM_CODES)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (start_q[n]),
            .rld_we   (hit_rld ? bus_be : 4'b0),
            .cnt_we   (hit_cnt ? bus_be : 4'b0),
            .ctl_lo_we(hit_ctl && bus_be[0]),
            .ctl_hi_we(hit_ctl && bus_be[1]),
            .wdata    (bus_wdata),
            .psc_d    (bus_wdata[2:0]),
            .ie_d     (bus_wdata[IE_BIT]),
            .flag_d   (bus_wdata[FLAG_BIT]),
            .rld_q    (rld_v[n]),
            .cnt_q    (cnt_v[n]),
            .ctl_q    (ctl_v[n]),
            .irq      (irq[n])
        );

        // R8
        irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[n]) |-> ($past(ctl_v[n][FLAG_BIT]) && $past(ctl_v[n][IE_BIT])));
    end

    // Read mux: unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_START) bus_rdata = 32'(start_q);
        for (int n = 0; n < int'(NUM_CH); n++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + RLD_REL)) bus_rdata = rld_v[n];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + CNT_REL)) bus_rdata = cnt_v[n];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + CTL_REL)) bus_rdata = 32'(ctl_v[n]);
        end
    end

    // R3
    start_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_START && bus_be[0] && !bus_wdata[0]) |=> !start_q[0]);
endmodule

// File: tb/tick_timer_bank_bench.sv
// Self-checking bench: sweeps prescaler codes and start counts on channel 0,
// then walks the special cases. Inputs change on the falling edge.
module tick_timer_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tick_timer_bank u_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] a_rld(int n); return 8'(8 + 12 * n);  endfunction
    function automatic logic [7:0] a_cnt(int n); return 8'(12 + 12 * n); endfunction
    function automatic logic [7:0] a_ctl(int n); return 8'(16 + 12 * n); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int n = 0; n < 3; n++) begin
            rd(a_rld(n), v); chk("R1 reload", v, 32'hFFFF_FFFF);
            rd(a_cnt(n), v); chk("R1 counter", v, 32'hFFFF_FFFF);
            rd(a_ctl(n), v); chk("R1 control", v, 32'h0);
        end
        rd(8'h04, v); chk("R1 start", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 unmapped offsets
        rd(8'h00, v); chk("R2 offset 0x00", v, 32'h0);
        rd(8'h2C, v); chk("R2 offset 0x2C", v, 32'h0);

        // R10 byte lanes
        wr(a_cnt(0), 32'hAABBCCDD, 4'b1111);
        wr(a_cnt(0), 32'h00000011, 4'b0001);
        rd(a_cnt(0), v); chk("R10 counter lane 0", v, 32'hAABBCC11);
        wr(a_ctl(0), 32'h0000_0123, 4'b0001);
        rd(a_ctl(0), v); chk("R10 control lane 0 only", v, 32'h0000_0023);

        // R4 R5 R8 sweep over codes and start counts
        for (int code = 0; code < 4; code++) begin
            for (int n0 = 0; n0 < 3; n0++) begin
                int dv;
                dv = 4 << (2 * code);
                wr(8'h04, 32'h0, 4'b0001);
                wr(a_ctl(0), 32'h20 | code, 4'b0011);
                wr(a_rld(0), 32'd7, 4'b1111);
                wr(a_cnt(0), 32'(n0), 4'b1111);
                idle(1);
                wr(8'h04, 32'h1, 4'b0001);
                idle(dv * (n0 + 1) - 1);
                rd(a_ctl(0), v); chk("R4 no flag before underflow", 32'(v[8]), 32'h0);
                rd(a_cnt(0), v); chk("R5 counter at zero", v, 32'h0);
                idle(1);
                rd(a_ctl(0), v); chk("R5 flag at underflow", 32'(v[8]), 32'h1);
                rd(a_cnt(0), v); chk("R5 reload value", v, 32'd7);
                chk("R8 irq one cycle late", 32'(irq[0]), 32'h0);
                idle(1);
                chk("R8 irq raised", 32'(irq[0]), 32'h1);
                idle(8 * dv - 2);
                rd(a_cnt(0), v); chk("R5 second period end", v, 32'h0);
                idle(1);
                rd(a_cnt(0), v); chk("R5 second reload", v, 32'd7);
            end
        end

        // R7 flag write semantics
        wr(8'h04, 32'h0, 4'b0001);
        wr(a_ctl(0), 32'h100, 4'b0010);
        rd(a_ctl(0), v); chk("R7 write 1 keeps flag", 32'(v[8]), 32'h1);
        wr(a_ctl(0), 32'h000, 4'b0010);
        rd(a_ctl(0), v); chk("R7 write 0 clears flag", 32'(v[8]), 32'h0);
        idle(1);
        chk("R8 irq drops after clear", 32'(irq[0]), 32'h0);

        // R7 underflow and clear on the same edge
        wr(a_ctl(0), 32'h20, 4'b0001);
        wr(a_cnt(0), 32'h0, 4'b1111);
        wr(8'h04, 32'h1, 4'b0001);
        idle(3);
        wr(a_ctl(0), 32'h000, 4'b0010);
        rd(a_ctl(0), v); chk("R7 underflow beats clear", 32'(v[8]), 32'h1);

        // R6 zero reload parks the channel
        wr(8'h04, 32'h0, 4'b0001);
        wr(a_ctl(0), 32'h000, 4'b0010);
        wr(a_rld(0), 32'h0, 4'b1111);
        wr(a_cnt(0), 32'd2, 4'b1111);
        wr(8'h04, 32'h1, 4'b0001);
        idle(12);
        rd(a_ctl(0), v); chk("R6 single-shot underflow", 32'(v[8]), 32'h1);
        wr(a_ctl(0), 32'h000, 4'b0010);
        idle(40);
        rd(a_ctl(0), v); chk("R6 no further flag", 32'(v[8]), 32'h0);
        rd(a_cnt(0), v); chk("R6 counter parked", v, 32'h0);
        wr(a_rld(0), 32'd3, 4'b1111);
        idle(8);
        rd(a_ctl(0), v); chk("R6 released by reload write", 32'(v[8]), 32'h1);

        // R9 reserved code freezes
        wr(8'h04, 32'h0, 4'b0001);
        wr(a_ctl(0), 32'h05, 4'b0011);
        wr(a_cnt(0), 32'd9, 4'b1111);
        wr(8'h04, 32'h1, 4'b0001);
        idle(100);
        rd(a_cnt(0), v); chk("R9 reserved code frozen", v, 32'd9);

        // R3 halt holds, restart resets the prescaler
        wr(8'h04, 32'h0, 4'b0001);
        wr(a_ctl(0), 32'h00, 4'b0011);
        wr(a_cnt(0), 32'd20, 4'b1111);
        wr(8'h04, 32'h1, 4'b0001);
        idle(10);
        rd(a_cnt(0), v); chk("R3 running decrements", v, 32'd18);
        wr(8'h04, 32'h0, 4'b0001);
        idle(30);
        rd(a_cnt(0), v); chk("R3 halted holds", v, 32'd18);
        wr(8'h04, 32'h1, 4'b0001);
        idle(3);
        rd(a_cnt(0), v); chk("R3 prescaler restarts from zero", v, 32'd18);
        idle(1);
        rd(a_cnt(0), v); chk("R3 first tick after restart", v, 32'd17);

        // R11 channel isolation
        wr(8'h04, 32'h0, 4'b0001);
        wr(a_cnt(0), 32'd50, 4'b1111);
        wr(a_ctl(1), 32'h00, 4'b0011);
        wr(a_cnt(1), 32'd5, 4'b1111);
        wr(8'h04, 32'h2, 4'b0001);
        idle(30);
        rd(a_cnt(0), v); chk("R11 idle channel untouched", v, 32'd50);
        rd(a_cnt(1), v); chk("R11 running channel", v, 32'hFFFF_FFFE);
        rd(a_cnt(2), v); chk("R11 third channel untouched", v, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule